// File: doc/BRIEF.md
# Converter Channel Power and Reference Mode Register

This block keeps the power state of each of eight converter channels and the enable bit of the internal voltage reference. A serial front end delivers a complete 32-bit command word together with a strobe that is high for one clock. The block decodes the command in the top nibble and updates its state on that clock edge. It does not model any analog circuitry. Its outputs are digital controls: a 2-bit output-termination mode for each channel, a powered-down flag for each channel, and the reference enable.

When a channel returns to normal operation, the block raises a wake pulse for that channel for one clock. Alongside the pulse it gives a source select that tells the channel update logic which value to drive. If the active-low load strobe is low at the waking edge, the channel resumes from its input register. If the strobe is high, the channel resumes from the DAC register it held before power-down. This block keeps no DAC register contents, so entering power-down can never alter them.

Top module: `dac_pwr_ref_ctrl`

## Requirements
- R1: After reset, every channel mode is 00, every powered-down flag is 0, the reference is off, and no wake pulse or source select is asserted.
- R2: A power command (command nibble bits 27:24 = 0100) sent with `exec_i` high sets the mode of each channel whose mask bit is 1. The mode comes from word bits 9:8 and the mask from bits 7:0, with bit 0 for channel 0 and bit 7 for channel 7. The new mode appears on `term_mode_o` bits [2i+1:2i] after that clock edge.
- R3: A channel whose mask bit is 0 keeps its current mode through a power command.
- R4: The mode encoding is 00 normal, 01 ground through the low-value load, 10 ground through the high-value load, and 11 high impedance. `pwr_down_o[i]` is 1 exactly when the mode of channel i is not 00.
- R5: A channel whose mode goes from a non-zero value to 00 raises `wake_o[i]` for exactly one clock after the edge that changed it. A channel that was already in normal mode never raises it.
- R6: When `wake_o[i]` rises, `wake_from_input_o[i]` is 1 if `ldac_n_i` was low at that edge (resume from the input register) and 0 if it was high (resume from the DAC register). It is never 1 without `wake_o[i]`.
- R7: A reference command (command nibble 1000) sets `ref_en_o` to word bit 0 after the edge. All other bits of the word are ignored.
- R8: A software reset command (command nibble 0111) returns every channel to mode 00 and turns the reference off. Channels that were powered down raise a wake pulse, following R5 and R6.
- R9: Nothing changes while `exec_i` is low. Command codes other than 0100, 0111 and 1000 have no effect. Bits 31:28, the address field 23:20 and bits 19:10 of a power command are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exec_i | input | 1 | One-cycle execute strobe for `cmd_word_i` |
| cmd_word_i | input | 32 | Decoded command word from the serial front end |
| ldac_n_i | input | 1 | Active-low load strobe level |
| term_mode_o | output | 16 | Termination mode, 2 bits per channel |
| pwr_down_o | output | 8 | Per-channel powered-down flag |
| ref_en_o | output | 1 | Internal reference enable |
| wake_o | output | 8 | One-cycle pulse for a channel leaving power-down |
| wake_from_input_o | output | 8 | With wake: 1 = resume from input register, 0 = from DAC register |

## Verification
Within a single command, waking and parking compete. A write of mode 00 whose mask covers both powered-down and running channels must wake only the powered-down ones. A software reset must wake every parked channel in the same cycle that it clears the reference. The bench provokes both cases. It sends a mask that mixes channels in each state, and it issues a reset while several channels sit in different termination modes. In each case it compares the wake and source vectors against masks computed from the modes it knows the channels held before the command. It then confirms that the wake pulses fall on the following clock.

// File: rtl/dac_pwr_pkg.sv
package dac_pwr_pkg;
  localparam int CMD_LSB = 24;
  localparam int CMD_W   = 4;
  localparam logic [CMD_W-1:0] CMD_POWER = 4'b0100;
  localparam logic [CMD_W-1:0] CMD_SWRST = 4'b0111;
  localparam logic [CMD_W-1:0] CMD_VREF  = 4'b1000;

  typedef enum logic [1:0] {
    TM_NORMAL = 2'b00,
    TM_LOW_R  = 2'b01,
    TM_HIGH_R = 2'b10,
    TM_FLOAT  = 2'b11
  } term_mode_t;

  function automatic logic [CMD_W-1:0] f_cmd(input logic [31:0] w);
    return w[CMD_LSB +: CMD_W];
  endfunction

  function automatic logic f_is_down(input term_mode_t m);
    return m != TM_NORMAL;
  endfunction

  function automatic logic f_leaves(input term_mode_t cur, input term_mode_t nxt);
    return f_is_down(cur) && !f_is_down(nxt);
  endfunction
endpackage

// File: rtl/dac_cmd_decode.sv
module dac_cmd_decode
  import dac_pwr_pkg::*;
#(
  parameter int N_CH = 8
) (
  input  logic                exec_i,
  input  logic [31:0]         word_i,
  output logic                pwr_we_o,
  output logic                swrst_o,
  output logic                ref_we_o,
  output logic                ref_val_o,
  output term_mode_t          mode_o,
  output logic [N_CH-1:0]     mask_o
);
  localparam int MODE_LSB = N_CH;

  logic [CMD_W-1:0] cmd;
  logic             unused_bits;

  always_comb begin
    cmd       = f_cmd(word_i);
    pwr_we_o  = exec_i && (cmd == CMD_POWER);
    swrst_o   = exec_i && (cmd == CMD_SWRST);
    ref_we_o  = exec_i && (cmd == CMD_VREF);
    ref_val_o = word_i[0];
    mode_o    = term_mode_t'(word_i[MODE_LSB +: 2]);
    mask_o    = word_i[N_CH-1:0];
  end

  assign unused_bits = ^{word_i[31:CMD_LSB+CMD_W], word_i[CMD_LSB-1:MODE_LSB+2]};
endmodule

// File: rtl/dac_chan_pwr.sv
module dac_chan_pwr
  import dac_pwr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       we_i,
  input  logic       clr_i,
  input  term_mode_t mode_i,
  input  logic       ldac_n_i,
  output term_mode_t mode_o,
  output logic       down_o,
  output logic       wake_o,
  output logic       from_input_o
);
  term_mode_t mode_q, mode_nxt;
  logic       leaving;

  always_comb begin
    mode_nxt = mode_q;
    if (clr_i)     mode_nxt = TM_NORMAL;
    else if (we_i) mode_nxt = mode_i;
    leaving = f_leaves(mode_q, mode_nxt);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q       <= TM_NORMAL;
      wake_o       <= 1'b0;
      from_input_o <= 1'b0;
    end else begin
      mode_q       <= mode_nxt;
      wake_o       <= leaving;
      from_input_o <= leaving && !ldac_n_i;
    end
  end

  assign mode_o = mode_q;
  assign down_o = f_is_down(mode_q);

  p_keep_unselected_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!we_i && !clr_i) |=> $stable(mode_q));
  p_wake_leaves_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wake_o |-> (mode_q == TM_NORMAL && $past(mode_q) != TM_NORMAL));
  p_wake_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wake_o |=> !wake_o);
  p_src_with_wake_r6: assert property (@(posedge clk) disable iff (!rst_n)
    from_input_o |-> wake_o);
  p_src_ldac_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (leaving && !ldac_n_i) |=> from_input_o);
endmodule

// File: rtl/dac_ref_ctrl.sv
module dac_ref_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic we_i,
  input  logic val_i,
  input  logic clr_i,
  output logic ref_en_o
);
  always_ff @(posedge clk) begin
    if (!rst_n)      ref_en_o <= 1'b0;
    else if (clr_i)  ref_en_o <= 1'b0;
    else if (we_i)   ref_en_o <= val_i;
  end

  p_ref_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && !clr_i) |=> (ref_en_o == $past(val_i)));
  p_ref_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> !ref_en_o);
endmodule

// File: rtl/dac_pwr_ref_ctrl.sv
module dac_pwr_ref_ctrl
  import dac_pwr_pkg::*;
#(
  parameter int N_CH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              exec_i,
  input  logic [31:0]       cmd_word_i,
  input  logic              ldac_n_i,
  output logic [2*N_CH-1:0] term_mode_o,
  output logic [N_CH-1:0]   pwr_down_o,
  output logic              ref_en_o,
  output logic [N_CH-1:0]   wake_o,
  output logic [N_CH-1:0]   wake_from_input_o
);
  logic            pwr_we, swrst, ref_we, ref_val;
  term_mode_t      new_mode;
  logic [N_CH-1:0] mask;

  dac_cmd_decode #(.N_CH(N_CH)) u_dec (
    .exec_i   (exec_i),
    .word_i   (cmd_word_i),
    .pwr_we_o (pwr_we),
    .swrst_o  (swrst),
    .ref_we_o (ref_we),
    .ref_val_o(ref_val),
    .mode_o   (new_mode),
    .mask_o   (mask)
  );

  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    term_mode_t ch_mode;
    dac_chan_pwr u_ch (
      .clk         (clk),
      .rst_n       (rst_n),
      .we_i        (pwr_we && mask[i]),
      .clr_i       (swrst),
      .mode_i      (new_mode),
      .ldac_n_i    (ldac_n_i),
      .mode_o      (ch_mode),
      .down_o      (pwr_down_o[i]),
      .wake_o      (wake_o[i]),
      .from_input_o(wake_from_input_o[i])
    );
    assign term_mode_o[2*i +: 2] = ch_mode;
  end

  dac_ref_ctrl u_ref (
    .clk     (clk),
    .rst_n   (rst_n),
    .we_i    (ref_we),
    .val_i   (ref_val),
    .clr_i   (swrst),
    .ref_en_o(ref_en_o)
  );

  p_hold_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !exec_i |=> ($stable(term_mode_o) && $stable(ref_en_o)));
  p_swrst_all_normal_r8: assert property (@(posedge clk) disable iff (!rst_n)
    swrst |=> (term_mode_o == '0));
  p_down_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_we && mask[0] && !swrst) |=> (pwr_down_o[0] == ($past(new_mode) != TM_NORMAL)));
endmodule

// File: tb/dac_pwr_ref_ctrl_tb.sv
module dac_pwr_ref_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        exec_i = 1'b0;
  logic [31:0] cmd_word_i = '0;
  logic        ldac_n_i = 1'b1;
  logic [15:0] term_mode_o;
  logic [7:0]  pwr_down_o, wake_o, wake_from_input_o;
  logic        ref_en_o;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  dac_pwr_ref_ctrl u_dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] pw(input logic [1:0] m, input logic [7:0] msk);
    return {4'hB, 4'b0100, 4'h6, 10'h2D3, m, msk};
  endfunction

  function automatic logic [15:0] modes_of(input logic [1:0] m [8]);
    logic [15:0] r;
    for (int i = 0; i < 8; i++) r[2*i +: 2] = m[i];
    return r;
  endfunction

  function automatic logic [7:0] down_of(input logic [1:0] m [8]);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = (m[i] != 2'b00);
    return r;
  endfunction

  logic [1:0] mdl [8];
  logic       mref;

  task automatic send(input logic [31:0] w, input logic ld);
    @(negedge clk);
    cmd_word_i = w; exec_i = 1'b1; ldac_n_i = ld;
    @(negedge clk);
    exec_i = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 modes", {16'h0, term_mode_o}, 32'h0);
    chk("R1 down", {24'h0, pwr_down_o}, 32'h0);
    chk("R1 ref", {31'h0, ref_en_o}, 32'h0);
    chk("R1 wake", {16'h0, wake_o, wake_from_input_o}, 32'h0);
  endtask

  task automatic t_mask();
    send(pw(2'b01, 8'h05), 1'b1); mdl[0] = 2'b01; mdl[2] = 2'b01;
    chk("R2 low-load A,C", {16'h0, term_mode_o}, {16'h0, modes_of(mdl)});
    send(pw(2'b11, 8'h80), 1'b1); mdl[7] = 2'b11;
    chk("R3 unmasked keep", {16'h0, term_mode_o}, {16'h0, modes_of(mdl)});
    send(pw(2'b10, 8'h02), 1'b0); mdl[1] = 2'b10;
    chk("R2 high-load B", {16'h0, term_mode_o}, {16'h0, modes_of(mdl)});
    chk("R4 down flags", {24'h0, pwr_down_o}, {24'h0, down_of(mdl)});
    chk("R5 no wake on park", {24'h0, wake_o}, 32'h0);
  endtask

  task automatic t_wake();
    // mixed mask: channel 0 parked, 4 running
    send(pw(2'b00, 8'h11), 1'b0); mdl[0] = 2'b00;
    chk("R5 wake only parked", {24'h0, wake_o}, 32'h01);
    chk("R6 from input", {24'h0, wake_from_input_o}, 32'h01);
    chk("R4 down after wake", {24'h0, pwr_down_o}, {24'h0, down_of(mdl)});
    @(negedge clk);
    chk("R5 pulse one cycle", {24'h0, wake_o}, 32'h0);
    send(pw(2'b00, 8'h04), 1'b1); mdl[2] = 2'b00;
    chk("R5 wake C", {24'h0, wake_o}, 32'h04);
    chk("R6 from DAC reg", {24'h0, wake_from_input_o}, 32'h0);
  endtask

  task automatic t_ref();
    send({4'h7, 4'b1000, 4'hF, 19'h7FFFF, 1'b1}, 1'b1); mref = 1'b1;
    chk("R7 ref on", {31'h0, ref_en_o}, {31'h0, mref});
    send({4'hF, 4'b1000, 4'hA, 19'h5A5A5, 1'b0}, 1'b1); mref = 1'b0;
    chk("R7 ref off, other bits ignored", {31'h0, ref_en_o}, {31'h0, mref});
    send({4'h0, 4'b1000, 4'h0, 19'h0, 1'b1}, 1'b1); mref = 1'b1;
    chk("R7 ref on again", {31'h0, ref_en_o}, {31'h0, mref});
  endtask

  task automatic t_ignore();
    @(negedge clk);
    cmd_word_i = pw(2'b11, 8'hFF); exec_i = 1'b0;
    repeat (3) @(negedge clk);
    chk("R9 no exec modes", {16'h0, term_mode_o}, {16'h0, modes_of(mdl)});
    send({4'h0, 4'b0011, 4'h0, 10'h0, 2'b11, 8'hFF}, 1'b1);
    chk("R9 other cmd modes", {16'h0, term_mode_o}, {16'h0, modes_of(mdl)});
    send({4'h0, 4'b0001, 4'h0, 19'h0, 1'b0}, 1'b1);
    chk("R9 other cmd ref", {31'h0, ref_en_o}, {31'h0, mref});
  endtask

  task automatic t_swrst();
    logic [7:0] was;
    send(pw(2'b01, 8'h30), 1'b1); mdl[4] = 2'b01; mdl[5] = 2'b01;
    was = down_of(mdl);
    send({4'h9, 4'b0111, 4'h3, 20'hFFFFF}, 1'b0);
    for (int i = 0; i < 8; i++) mdl[i] = 2'b00;
    mref = 1'b0;
    chk("R8 modes cleared", {16'h0, term_mode_o}, 32'h0);
    chk("R8 ref cleared", {31'h0, ref_en_o}, 32'h0);
    chk("R8 wake parked", {24'h0, wake_o}, {24'h0, was});
    chk("R8 source input", {24'h0, wake_from_input_o}, {24'h0, was});
    @(negedge clk);
    chk("R8 wake falls", {24'h0, wake_o}, 32'h0);
  endtask

  initial begin
    for (int i = 0; i < 8; i++) mdl[i] = 2'b00;
    mref = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_mask();
    t_wake();
    t_ref();
    t_ignore();
    t_swrst();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #40000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule